// File: doc/BRIEF.md
# Pipeline Partition Test-Mode Router

This block wraps a chain of three registered processing stages, here called head, middle and tail, and places steering multiplexers at the stage boundaries. A two-bit mode input either runs the stages as one pipeline or connects the primary inputs and outputs around exactly one stage. In that isolated mode the selected stage can be driven and observed directly, without going through its neighbours. The mode bits act combinationally and only change routing. Stage contents are never cleared by a mode change, so a stage that is off the active path keeps its word until the path reaches it again.

Data moves on a valid/ready stream at both ends. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. The output word is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word stays fixed. Each stage is a one-entry register slot. A full stage passes its ready signal upstream only while its own consumer is ready, so a stalled output fills the active path from its end backwards.

A build parameter selects the reduced variant. It has only two steering points, one in front of the middle stage and one behind it. In this variant the middle stage is still fully isolated. A head-stage test is observed through the middle stage, and a tail-stage test is fed through the middle stage.

Top module: `pipe_partition_wrap`

## Requirements
- R1: Mode code 2'b01 (bit 1 is T1, bit 0 is T2) is normal operation. The output word is tail(middle(head(x))), it appears three edges after the input edge, and the result is the same in both variants.
- R2: With mode 2'b00 in the full variant, the output is head(x) one edge after the input edge.
- R3: With mode 2'b10, in both variants, the output is middle(x) one edge after the input edge.
- R4: With mode 2'b11 in the full variant, the output is tail(x) one edge after the input edge.
- R5: In the reduced variant, mode 2'b00 gives middle(head(x)) after two edges, and mode 2'b11 gives tail(middle(x)) after two edges.
- R6: The stage transforms are fixed. Head adds ADD_A modulo 2^W, middle XORs with MASK_B, and tail rotates left by one bit and then XORs with MIX_C.
- R7: While `out_valid` is high, `out_ready` is low and the mode is unchanged, `out_valid` and `out_data` hold. Words leave in the order they were taken, with none lost and none repeated.
- R8: In normal mode with `out_ready` low, exactly three words are accepted before `in_ready` goes low.
- R9: A change on `mode` moves the output steering in the same cycle, with no clock edge needed.
- R10: A mode change does not clear any stage. A stage that is off the active path ignores input traffic and keeps its word.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Bit 1 = T1, bit 0 = T2; selects normal or single-stage routing |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Active path can take a word |
| in_data | input | W | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | W | Output word |

## Verification
The hardest case to reach from the ports is a word parked in a stage that is off the path, surviving traffic through another stage, and reappearing unchanged later. The stimulus sets up this case directly. It stalls the output in head-stage test mode, switches to tail mode and checks that the output drops at once. It then streams a word through the middle stage and switches back to check that the head word is still held. Stalling the full normal path checks the three-word fill limit and the order of release.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    MODE_TEST_A = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_TEST_B = 2'b10,
    MODE_TEST_C = 2'b11
  } pp_mode_e;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2
  } pp_stage_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XOR  = 2'd1,
    OP_ROTX = 2'd2
  } pp_op_e;

  // Routing decision for one mode: which stages sit on the active path,
  // which take their input from the primary inputs, and which one drives
  // the primary outputs.
  typedef struct packed {
    logic      a_on;
    logic      b_on;
    logic      c_on;
    logic      b_from_pi;
    logic      c_from_pi;
    pp_stage_e po_sel;
  } pp_route_t;

endpackage

// File: rtl/pp_route_decode.sv
module pp_route_decode
  import pp_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic [1:0] mode,
  output pp_route_t  route
);

  generate
    if (REDUCED) begin : g_half
      // Two steering points only: in front of and behind the middle stage.
      always_comb begin
        route = '{a_on: 1'b1, b_on: 1'b1, c_on: 1'b1,
                  b_from_pi: 1'b0, c_from_pi: 1'b0, po_sel: SRC_C};
        unique case (pp_mode_e'(mode))
          MODE_NORMAL: ;
          MODE_TEST_A: begin
            route.c_on   = 1'b0;
            route.po_sel = SRC_B;
          end
          MODE_TEST_B: begin
            route.a_on      = 1'b0;
            route.c_on      = 1'b0;
            route.b_from_pi = 1'b1;
            route.po_sel    = SRC_B;
          end
          MODE_TEST_C: begin
            route.a_on      = 1'b0;
            route.b_from_pi = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin : g_full
      always_comb begin
        route = '{a_on: 1'b1, b_on: 1'b1, c_on: 1'b1,
                  b_from_pi: 1'b0, c_from_pi: 1'b0, po_sel: SRC_C};
        unique case (pp_mode_e'(mode))
          MODE_NORMAL: ;
          MODE_TEST_A: begin
            route.b_on   = 1'b0;
            route.c_on   = 1'b0;
            route.po_sel = SRC_A;
          end
          MODE_TEST_B: begin
            route.a_on      = 1'b0;
            route.c_on      = 1'b0;
            route.b_from_pi = 1'b1;
            route.po_sel    = SRC_B;
          end
          MODE_TEST_C: begin
            route.a_on      = 1'b0;
            route.b_on      = 1'b0;
            route.c_from_pi = 1'b1;
          end
          default: ;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/pp_stage.sv
module pp_stage
  import pp_pkg::*;
#(
  parameter int           W  = 8,
  parameter pp_op_e       OP = OP_ADD,
  parameter logic [W-1:0] K  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic [W-1:0] f_val;
  logic         vld_q;
  logic [W-1:0] dat_q;

  generate
    if (OP == OP_ADD) begin : g_add
      assign f_val = up_data + K;
    end else if (OP == OP_XOR) begin : g_xor
      assign f_val = up_data ^ K;
    end else begin : g_rotx
      assign f_val = {up_data[W-2:0], up_data[W-1]} ^ K;
    end
  endgenerate

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_valid && up_ready) begin
      vld_q <= 1'b1;
      dat_q <= f_val;
    end else if (dn_ready) begin
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pp_out_sel.sv
module pp_out_sel
  import pp_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSTG = 3
) (
  input  pp_stage_e       sel,
  input  logic [NSTG-1:0] stg_valid,
  input  logic [W-1:0]    stg_data [NSTG],
  output logic            out_valid,
  output logic [W-1:0]    out_data
);

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    for (int k = 0; k < NSTG; k++) begin
      if (sel == pp_stage_e'(k)) begin
        out_valid = stg_valid[k];
        out_data  = stg_data[k];
      end
    end
  end

endmodule

// File: rtl/pipe_partition_wrap.sv
module pipe_partition_wrap
  import pp_pkg::*;
#(
  parameter int           W       = 8,
  parameter bit           REDUCED = 1'b0,
  parameter logic [W-1:0] ADD_A   = 'h11,
  parameter logic [W-1:0] MASK_B  = 'h5A,
  parameter logic [W-1:0] MIX_C   = 'h0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int NSTG = 3;

  pp_route_t         rt;
  logic [NSTG-1:0]   s_on;
  logic [NSTG-1:0]   s_from_pi;
  logic [NSTG-1:0]   s_up_v;
  logic [NSTG-1:0]   s_up_r;
  logic [NSTG-1:0]   s_dn_v;
  logic [NSTG-1:0]   s_dn_r;
  logic [W-1:0]      s_up_d [NSTG];
  logic [W-1:0]      s_dn_d [NSTG];

  pp_route_decode #(.REDUCED(REDUCED)) dec_i (
    .mode  (mode),
    .route (rt)
  );

  assign s_on      = {rt.c_on, rt.b_on, rt.a_on};
  assign s_from_pi = {rt.c_from_pi, rt.b_from_pi, 1'b1};

  generate
    for (genvar k = 0; k < NSTG; k++) begin : g_stg
      localparam pp_op_e       OPK = (k == 0) ? OP_ADD : (k == 1) ? OP_XOR : OP_ROTX;
      localparam logic [W-1:0] KK  = (k == 0) ? ADD_A : (k == 1) ? MASK_B : MIX_C;

      logic         chain_v;
      logic [W-1:0] chain_d;
      logic         next_take;

      if (k == 0) begin : g_head
        assign chain_v = 1'b0;
        assign chain_d = '0;
      end else begin : g_link
        assign chain_v = s_dn_v[k-1];
        assign chain_d = s_dn_d[k-1];
      end

      if (k == NSTG - 1) begin : g_last
        assign next_take = 1'b0;
      end else begin : g_mid
        assign next_take = s_on[k+1] && !s_from_pi[k+1] && s_up_r[k+1];
      end

      // Off-path stages see no input traffic and no drain: they hold.
      assign s_up_v[k] = s_on[k] && (s_from_pi[k] ? in_valid : chain_v);
      assign s_up_d[k] = s_from_pi[k] ? in_data : chain_d;
      assign s_dn_r[k] = s_on[k] && ((rt.po_sel == pp_stage_e'(k)) ? out_ready : next_take);

      pp_stage #(.W(W), .OP(OPK), .K(KK)) stg_i (
        .clk      (clk),
        .rst      (rst),
        .up_valid (s_up_v[k]),
        .up_ready (s_up_r[k]),
        .up_data  (s_up_d[k]),
        .dn_valid (s_dn_v[k]),
        .dn_ready (s_dn_r[k]),
        .dn_data  (s_dn_d[k])
      );
    end
  endgenerate

  assign in_ready = |(s_on & s_from_pi & s_up_r);

  pp_out_sel #(.W(W), .NSTG(NSTG)) osel_i (
    .sel       (rt.po_sel),
    .stg_valid (s_dn_v),
    .stg_data  (s_dn_d),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/pp_wrap_chk.sv
module pp_wrap_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  // R11
  reset_clears_out_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R7
  stall_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (!$stable(mode) || (out_valid && $stable(out_data))));

  // R8
  normal_full_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !in_ready) |-> (out_valid && !out_ready));

  // R3
  mid_test_one_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && in_valid && in_ready) |=> (!$stable(mode) || out_valid));

endmodule

bind pipe_partition_wrap pp_wrap_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/pipe_partition_wrap_tb_top.sv
`timescale 1ns/1ps
module pipe_partition_wrap_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b01;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         red_en = 1'b0;
  logic         f_out_ready = 1'b1;
  logic         r_out_ready = 1'b1;
  logic         f_in_ready, r_in_ready;
  logic         f_out_valid, r_out_valid;
  logic [W-1:0] f_out_data, r_out_data;
  logic         r_in_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  assign r_in_valid = in_valid && red_en;

  pipe_partition_wrap #(.W(W), .REDUCED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .in_valid(in_valid), .in_ready(f_in_ready), .in_data(in_data),
    .out_valid(f_out_valid), .out_ready(f_out_ready), .out_data(f_out_data)
  );

  pipe_partition_wrap #(.W(W), .REDUCED(1'b1)) dut_red_i (
    .clk(clk), .rst(rst), .mode(mode),
    .in_valid(r_in_valid), .in_ready(r_in_ready), .in_data(in_data),
    .out_valid(r_out_valid), .out_ready(r_out_ready), .out_data(r_out_data)
  );

  // Stage models from R6
  function automatic logic [W-1:0] fa(input logic [W-1:0] x); return x + 8'h11; endfunction
  function automatic logic [W-1:0] fb(input logic [W-1:0] x); return x ^ 8'h5A; endfunction
  function automatic logic [W-1:0] fc(input logic [W-1:0] x); return {x[W-2:0], x[W-1]} ^ 8'h0F; endfunction

  function automatic logic [W-1:0] exp_full(input logic [1:0] m, input logic [W-1:0] x);
    case (m)
      2'b01:   return fc(fb(fa(x)));
      2'b00:   return fa(x);
      2'b10:   return fb(x);
      default: return fc(x);
    endcase
  endfunction

  function automatic logic [W-1:0] exp_red(input logic [1:0] m, input logic [W-1:0] x);
    case (m)
      2'b01:   return fc(fb(fa(x)));
      2'b00:   return fb(fa(x));
      2'b10:   return fb(x);
      default: return fc(fb(x));
    endcase
  endfunction

  function automatic int lat_full(input logic [1:0] m); return (m == 2'b01) ? 3 : 1; endfunction
  function automatic int lat_red(input logic [1:0] m);
    case (m)
      2'b01:   return 3;
      2'b10:   return 1;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m, input bit red);
    if (m == 2'b01) return "R1";
    if (m == 2'b10) return "R3";
    if (red)        return "R5";
    return (m == 2'b00) ? "R2" : "R4";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // {mode, data}
  localparam logic [9:0] VEC [8] = '{
    {2'b01, 8'h00}, {2'b00, 8'hFF}, {2'b10, 8'hA5}, {2'b11, 8'h80},
    {2'b01, 8'h7E}, {2'b00, 8'h01}, {2'b10, 8'h00}, {2'b11, 8'h3C}
  };

  task automatic run_vec(input logic [1:0] m, input logic [W-1:0] d);
    bit got_f = 0, got_r = 0;
    int lf = 0, lr = 0;
    logic [W-1:0] df = '0, dr = '0;
    @(negedge clk);
    mode = m; in_data = d; in_valid = 1'b1; red_en = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (c == 1) in_valid = 1'b0;
      if (!got_f && f_out_valid) begin got_f = 1; lf = c; df = f_out_data; end
      if (!got_r && r_out_valid) begin got_r = 1; lr = c; dr = r_out_data; end
    end
    check(got_f && df == exp_full(m, d), req_of(m, 0), df, exp_full(m, d));
    check(lf == lat_full(m), req_of(m, 0), lf, lat_full(m));
    check(got_r && dr == exp_red(m, d), req_of(m, 1), dr, exp_red(m, d));
    check(lr == lat_red(m), req_of(m, 1), lr, lat_red(m));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        finish_up();
      end
    end
  end

  initial begin
    logic [W-1:0] words [4];
    logic [W-1:0] held;
    int got;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(!f_out_valid && !r_out_valid, "R11", {f_out_valid, r_out_valid}, 0);
    check(f_in_ready && r_in_ready, "R11", {f_in_ready, r_in_ready}, 2'b11);

    // Table walk: R1..R6 in both variants
    for (int i = 0; i < 8; i++) run_vec(VEC[i][9:8], VEC[i][7:0]);

    // R8 / R7: stalled normal path on the full variant
    @(negedge clk);
    red_en = 1'b0; mode = 2'b01; f_out_ready = 1'b0;
    words = '{8'h10, 8'h24, 8'h9C, 8'hE1};
    for (int i = 0; i < 3; i++) begin
      in_data = words[i]; in_valid = 1'b1;
      @(negedge clk);
    end
    in_data = words[3];
    check(!f_in_ready, "R8", f_in_ready, 0);
    repeat (2) @(negedge clk);
    check(!f_in_ready, "R8", f_in_ready, 0);
    check(f_out_valid && f_out_data == exp_full(2'b01, words[0]), "R7", f_out_data, exp_full(2'b01, words[0]));
    f_out_ready = 1'b1;
    #1;
    check(f_in_ready, "R8", f_in_ready, 1);
    got = 0;
    for (int c = 0; c < 8; c++) begin
      if (f_out_valid && got < 4) begin
        check(f_out_data == exp_full(2'b01, words[got]), "R7", f_out_data, exp_full(2'b01, words[got]));
        got++;
      end
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(got == 4, "R7", got, 4);
    check(!f_out_valid, "R7", f_out_valid, 0);

    // R9 / R10: parked head word across mode changes (full variant)
    mode = 2'b00; f_out_ready = 1'b0; in_data = 8'h3C; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = fa(8'h3C);
    check(f_out_valid && f_out_data == held, "R2", f_out_data, held);
    mode = 2'b11;
    #1;
    check(!f_out_valid, "R9", f_out_valid, 0);
    mode = 2'b00;
    #1;
    check(f_out_valid && f_out_data == held, "R9", f_out_data, held);
    mode = 2'b10; f_out_ready = 1'b1; in_data = 8'h81; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(f_out_valid && f_out_data == fb(8'h81), "R10", f_out_data, fb(8'h81));
    @(negedge clk);
    check(!f_out_valid, "R10", f_out_valid, 0);
    mode = 2'b00;
    #1;
    check(f_out_valid && f_out_data == held, "R10", f_out_data, held);
    @(negedge clk);
    check(!f_out_valid, "R10", f_out_valid, 0);

    finish_up();
  end

endmodule